// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block makes the keep-or-drop decision for each received Ethernet frame. When the receive parser reaches the end of a frame, it pulses a strobe and presents a one-cycle summary of that frame. The summary holds the destination address, a flag for an exact station-address hit, a flag for a type-ID hit, the VLAN-tag flag, the type/length field, the measured byte length, the FCS-error flag and a valid-pause-frame flag. Static configuration inputs and a 64-bit hash table steer the decision.

Two clock edges after the strobe, the filter raises a one-cycle result-valid pulse. With it come an accept bit, a drop-reason code, the length to report for the frame and the FCS status carried through. These result outputs hold their values until the next decision. The checks run in a fixed priority order:

1. frame integrity
2. size limit
3. length-field consistency
4. VLAN-only filtering
5. address acceptance

Address acceptance combines station match, broadcast blocking, copy-all, unicast and multicast hashing, type-ID match and a pause-frame override.

Top module: `eth_rx_filter`

## Requirements
- R1: A frame summary presented with `frameEnd` high at clock edge k produces its result at edge k+2. `resultValid` is high for exactly the cycle after edge k+2, and `accept`, `dropReason`, `frameLen` and `fcsFlag` keep their values until the next result.
- R2: While `rstN` is low, all outputs are zero.
- R3: A frame with `fcsBad` set is dropped with reason 1 unless `ignoreFcs` is set. `fcsFlag` reports `fcsBad` of the frame in every case.
- R4: A frame longer than the size limit is dropped with reason 2. The limit is 1518 bytes by default, 1536 bytes with `bigEn`, and 10240 bytes with `jumboEn` (`jumboEn` wins over `bigEn`).
- R5: With `lenChkEn` set, a frame whose `typeLen` is below 0x0600 and whose `rxLen` is less than `typeLen` is dropped with reason 3. A `typeLen` of 0x0600 or more is never checked this way.
- R6: With `vlanOnly` set, a frame without a VLAN tag is dropped with reason 4.
- R7: A destination of all ones is accepted as broadcast when `noBcast` is clear. When `noBcast` is set it is dropped with reason 5, unless `copyAll` is set.
- R8: With `copyAll` set, a frame that passed the earlier checks is accepted whatever its destination address.
- R9: The hash index bit i is the XOR of `destAddr` bits i, i+6, i+12, … up to bit 47. The frame passes when `hashReg` at that index is set and the matching enable is on. The enable is `mcHashEn` when `destAddr[0]` (the group bit of the first address byte, held in bits 7:0) is 1, and `ucHashEn` otherwise.
- R10: With `noPauseCopy` set, a frame with `pauseValid` set is not accepted through copy-all, hash, broadcast or type-ID match. It is still accepted when `specMatch` is set.
- R11: `frameLen` equals `rxLen` when `stripFcs` is clear. When `stripFcs` is set it equals `rxLen` minus 4, floored at 0.
- R12: `dropReason` is 0 when accepted. Otherwise it is the first failing check in the order 1 FCS, 2 size, 3 length field, 4 VLAN, 5 address, and `accept` is 1 exactly when `dropReason` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameEnd | input | 1 | Frame summary present this cycle |
| destAddr | input | 48 | Destination address, first byte in bits 7:0 |
| specMatch | input | 1 | Exact station address hit |
| typeMatch | input | 1 | Type-ID hit |
| vlanTagged | input | 1 | Frame carries a VLAN tag |
| typeLen | input | 16 | Type/length field |
| rxLen | input | LEN_W (14) | Measured frame length in bytes |
| fcsBad | input | 1 | FCS check failed |
| pauseValid | input | 1 | Frame is a valid pause frame |
| noBcast | input | 1 | Block broadcast destination |
| copyAll | input | 1 | Accept every frame passing earlier checks |
| ucHashEn | input | 1 | Enable hashing for unicast |
| mcHashEn | input | 1 | Enable hashing for multicast |
| vlanOnly | input | 1 | Drop untagged frames |
| bigEn | input | 1 | Raise size limit to 1536 |
| jumboEn | input | 1 | Raise size limit to 10240 |
| ignoreFcs | input | 1 | Keep frames with FCS errors |
| lenChkEn | input | 1 | Enable length-field check |
| noPauseCopy | input | 1 | Block pause frames from non-exact routes |
| stripFcs | input | 1 | Report length without FCS |
| hashReg | input | 64 | Hash table |
| resultValid | output | 1 | Result pulse |
| accept | output | 1 | Frame kept |
| dropReason | output | 3 | Drop reason code |
| frameLen | output | LEN_W (14) | Reported frame length |
| fcsFlag | output | 1 | FCS error status of the frame |

## Verification
The bench builds the filter with its default parameters: a 48-bit address, a 6-bit hash index and size limits of 1518, 1536 and 10240 bytes. With these values every size limit can be probed one byte on either side, and the jumbo edge at 10240 fits inside the 14-bit length. Because the index is 6 bits, the hash table is exactly the 64-bit register. A hand-chosen address can then be steered onto a chosen table bit, and the unicast and multicast enables can be told apart through the group bit.

// File: rtl/rxflt_pkg.sv
package rxflt_pkg;

  typedef enum logic [2:0] {
    RSN_OK   = 3'd0,
    RSN_FCS  = 3'd1,
    RSN_SIZE = 3'd2,
    RSN_LENF = 3'd3,
    RSN_VLAN = 3'd4,
    RSN_ADDR = 3'd5
  } reason_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;
    logic decide;
  } strobes_t;

  localparam logic [15:0] TYPE_THRESH = 16'h0600;

endpackage

// File: rtl/rxflt_ctrl.sv
module rxflt_ctrl
  import rxflt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameEnd,
  output strobes_t stb,
  output logic     resultValid
);

  logic decideQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decideQ     <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      decideQ     <= frameEnd;
      resultValid <= decideQ;
    end
  end

  always_comb begin
    stb.capture = frameEnd;
    stb.decide  = decideQ;
  end

endmodule

// File: rtl/rxflt_dp.sv
module rxflt_dp
  import rxflt_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_W    = 6,
  parameter int LEN_W     = 14,
  parameter int MAX_STD   = 1518,
  parameter int MAX_BIG   = 1536,
  parameter int MAX_JUMBO = 10240,
  localparam int TBL_W    = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] destAddr,
  input  logic              specMatch,
  input  logic              typeMatch,
  input  logic              vlanTagged,
  input  logic [15:0]       typeLen,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              fcsBad,
  input  logic              pauseValid,
  input  logic              noBcast,
  input  logic              copyAll,
  input  logic              ucHashEn,
  input  logic              mcHashEn,
  input  logic              vlanOnly,
  input  logic              bigEn,
  input  logic              jumboEn,
  input  logic              ignoreFcs,
  input  logic              lenChkEn,
  input  logic              noPauseCopy,
  input  logic              stripFcs,
  input  logic [TBL_W-1:0]  hashReg,
  output logic              accept,
  output reason_e           dropReason,
  output logic [LEN_W-1:0]  frameLen,
  output logic              fcsFlag
);

  localparam logic [LEN_W-1:0] LIM_STD   = LEN_W'(MAX_STD);
  localparam logic [LEN_W-1:0] LIM_BIG   = LEN_W'(MAX_BIG);
  localparam logic [LEN_W-1:0] LIM_JUMBO = LEN_W'(MAX_JUMBO);
  localparam logic [LEN_W-1:0] FCS_BYTES = LEN_W'(4);

  // captured frame summary
  logic [ADDR_W-1:0] sAddr;
  logic              sSpec, sType, sVlan, sFcs, sPause;
  logic [15:0]       sTypeLen;
  logic [LEN_W-1:0]  sLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sAddr    <= '0;
      sSpec    <= 1'b0;
      sType    <= 1'b0;
      sVlan    <= 1'b0;
      sFcs     <= 1'b0;
      sPause   <= 1'b0;
      sTypeLen <= '0;
      sLen     <= '0;
    end else if (stb.capture) begin
      sAddr    <= destAddr;
      sSpec    <= specMatch;
      sType    <= typeMatch;
      sVlan    <= vlanTagged;
      sFcs     <= fcsBad;
      sPause   <= pauseValid;
      sTypeLen <= typeLen;
      sLen     <= rxLen;
    end
  end

  // folded XOR hash, one lane per index bit
  function automatic logic [ADDR_W-1:0] laneMask(input int lane);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int k = lane; k < ADDR_W; k += HASH_W) m[k] = 1'b1;
    return m;
  endfunction

  logic [HASH_W-1:0] hashIdx;
  for (genvar b = 0; b < HASH_W; b++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE = laneMask(b);
    assign hashIdx[b] = ^(sAddr & LANE);
  end

  // size limit selection
  logic [LEN_W-1:0] sizeLimit;
  always_comb begin
    if (jumboEn)    sizeLimit = LIM_JUMBO;
    else if (bigEn) sizeLimit = LIM_BIG;
    else            sizeLimit = LIM_STD;
  end

  // individual check outcomes
  logic isGroup, isBcast, bcastBlocked, pauseBlock, hashHit, looseOk, addrOk;
  logic failFcs, failSize, failLenF, failVlan;
  logic [31:0] lenWide, fieldWide;

  always_comb begin
    isGroup      = sAddr[0];
    isBcast      = &sAddr;
    bcastBlocked = isBcast && noBcast;
    pauseBlock   = sPause && noPauseCopy;
    hashHit      = hashReg[hashIdx] && (isGroup ? mcHashEn : ucHashEn);
    looseOk      = copyAll ||
                   (!bcastBlocked && (hashHit || sType || isBcast));
    addrOk       = (sSpec && !bcastBlocked) || (!pauseBlock && looseOk);

    lenWide   = 32'(sLen);
    fieldWide = 32'(sTypeLen);
    failFcs   = sFcs && !ignoreFcs;
    failSize  = sLen > sizeLimit;
    failLenF  = lenChkEn && (sTypeLen < TYPE_THRESH) && (lenWide < fieldWide);
    failVlan  = vlanOnly && !sVlan;
  end

  reason_e reasonNext;
  always_comb begin
    if (failFcs)       reasonNext = RSN_FCS;
    else if (failSize) reasonNext = RSN_SIZE;
    else if (failLenF) reasonNext = RSN_LENF;
    else if (failVlan) reasonNext = RSN_VLAN;
    else if (!addrOk)  reasonNext = RSN_ADDR;
    else               reasonNext = RSN_OK;
  end

  logic [LEN_W-1:0] lenNext;
  always_comb begin
    if (!stripFcs)              lenNext = sLen;
    else if (sLen >= FCS_BYTES) lenNext = sLen - FCS_BYTES;
    else                        lenNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept     <= 1'b0;
      dropReason <= RSN_OK;
      frameLen   <= '0;
      fcsFlag    <= 1'b0;
    end else if (stb.decide) begin
      accept     <= (reasonNext == RSN_OK);
      dropReason <= reasonNext;
      frameLen   <= lenNext;
      fcsFlag    <= sFcs;
    end
  end

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import rxflt_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_W    = 6,
  parameter int LEN_W     = 14,
  parameter int MAX_STD   = 1518,
  parameter int MAX_BIG   = 1536,
  parameter int MAX_JUMBO = 10240,
  localparam int TBL_W    = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameEnd,
  input  logic [ADDR_W-1:0] destAddr,
  input  logic              specMatch,
  input  logic              typeMatch,
  input  logic              vlanTagged,
  input  logic [15:0]       typeLen,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              fcsBad,
  input  logic              pauseValid,
  input  logic              noBcast,
  input  logic              copyAll,
  input  logic              ucHashEn,
  input  logic              mcHashEn,
  input  logic              vlanOnly,
  input  logic              bigEn,
  input  logic              jumboEn,
  input  logic              ignoreFcs,
  input  logic              lenChkEn,
  input  logic              noPauseCopy,
  input  logic              stripFcs,
  input  logic [TBL_W-1:0]  hashReg,
  output logic              resultValid,
  output logic              accept,
  output logic [2:0]        dropReason,
  output logic [LEN_W-1:0]  frameLen,
  output logic              fcsFlag
);

  strobes_t stb;
  reason_e  reasonQ;

  rxflt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameEnd   (frameEnd),
    .stb        (stb),
    .resultValid(resultValid)
  );

  rxflt_dp #(
    .ADDR_W   (ADDR_W),
    .HASH_W   (HASH_W),
    .LEN_W    (LEN_W),
    .MAX_STD  (MAX_STD),
    .MAX_BIG  (MAX_BIG),
    .MAX_JUMBO(MAX_JUMBO)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .destAddr   (destAddr),
    .specMatch  (specMatch),
    .typeMatch  (typeMatch),
    .vlanTagged (vlanTagged),
    .typeLen    (typeLen),
    .rxLen      (rxLen),
    .fcsBad     (fcsBad),
    .pauseValid (pauseValid),
    .noBcast    (noBcast),
    .copyAll    (copyAll),
    .ucHashEn   (ucHashEn),
    .mcHashEn   (mcHashEn),
    .vlanOnly   (vlanOnly),
    .bigEn      (bigEn),
    .jumboEn    (jumboEn),
    .ignoreFcs  (ignoreFcs),
    .lenChkEn   (lenChkEn),
    .noPauseCopy(noPauseCopy),
    .stripFcs   (stripFcs),
    .hashReg    (hashReg),
    .accept     (accept),
    .dropReason (reasonQ),
    .frameLen   (frameLen),
    .fcsFlag    (fcsFlag)
  );

  assign dropReason = reasonQ;

endmodule

// File: rtl/rxflt_chk.sv
module rxflt_chk #(
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameEnd,
  input logic [LEN_W-1:0] rxLen,
  input logic             fcsBad,
  input logic             stripFcs,
  input logic             resultValid,
  input logic             accept,
  input logic [2:0]       dropReason,
  input logic [LEN_W-1:0] frameLen,
  input logic             fcsFlag
);

  // R1
  result_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> ##2 resultValid);

  // R1
  result_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(frameEnd, 2));

  // R12
  accept_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (accept == (dropReason == 3'd0)) && (dropReason <= 3'd5));

  // R3
  fcs_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (fcsFlag == $past(fcsBad, 2)));

  // R11
  plain_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !stripFcs && $stable(stripFcs)) |-> (frameLen == $past(rxLen, 2)));

  // R2
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (!resultValid && !accept && dropReason == 3'd0 && frameLen == '0 && !fcsFlag);
    end
  end

endmodule

bind eth_rx_filter rxflt_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameEnd   (frameEnd),
  .rxLen      (rxLen),
  .fcsBad     (fcsBad),
  .stripFcs   (stripFcs),
  .resultValid(resultValid),
  .accept     (accept),
  .dropReason (dropReason),
  .frameLen   (frameLen),
  .fcsFlag    (fcsFlag)
);

// File: tb/eth_rx_filter_test.sv
module eth_rx_filter_test;

  localparam int LEN_W = 14;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameEnd = 1'b0;
  logic [47:0] destAddr;
  logic specMatch, typeMatch, vlanTagged, fcsBad, pauseValid;
  logic [15:0] typeLen;
  logic [LEN_W-1:0] rxLen;
  logic noBcast, copyAll, ucHashEn, mcHashEn, vlanOnly, bigEn, jumboEn;
  logic ignoreFcs, lenChkEn, noPauseCopy, stripFcs;
  logic [63:0] hashReg;
  logic resultValid, accept, fcsFlag;
  logic [2:0] dropReason;
  logic [LEN_W-1:0] frameLen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eth_rx_filter uut (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .destAddr(destAddr),
    .specMatch(specMatch), .typeMatch(typeMatch), .vlanTagged(vlanTagged),
    .typeLen(typeLen), .rxLen(rxLen), .fcsBad(fcsBad), .pauseValid(pauseValid),
    .noBcast(noBcast), .copyAll(copyAll), .ucHashEn(ucHashEn), .mcHashEn(mcHashEn),
    .vlanOnly(vlanOnly), .bigEn(bigEn), .jumboEn(jumboEn), .ignoreFcs(ignoreFcs),
    .lenChkEn(lenChkEn), .noPauseCopy(noPauseCopy), .stripFcs(stripFcs),
    .hashReg(hashReg), .resultValid(resultValid), .accept(accept),
    .dropReason(dropReason), .frameLen(frameLen), .fcsFlag(fcsFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic defaults();
    destAddr = 48'h0000_0000_00A2; specMatch = 1'b1; typeMatch = 1'b0;
    vlanTagged = 1'b0; typeLen = 16'h0800; rxLen = LEN_W'(64);
    fcsBad = 1'b0; pauseValid = 1'b0;
    noBcast = 1'b0; copyAll = 1'b0; ucHashEn = 1'b0; mcHashEn = 1'b0;
    vlanOnly = 1'b0; bigEn = 1'b0; jumboEn = 1'b0; ignoreFcs = 1'b0;
    lenChkEn = 1'b0; noPauseCopy = 1'b0; stripFcs = 1'b0; hashReg = '0;
  endtask

  // pulse frameEnd, sample in the cycle after the second edge
  task automatic runFrame();
    @(negedge clk) frameEnd = 1'b1;
    @(negedge clk) frameEnd = 1'b0;
    @(negedge clk);
  endtask

  task automatic expectResult(input string tag, input int reason);
    runFrame();
    chk({tag, " valid"}, int'(resultValid), 1);
    chk({tag, " reason"}, int'(dropReason), reason);
    chk({tag, " accept"}, int'(accept), (reason == 0) ? 1 : 0);
  endtask

  function automatic int hashOf(input logic [47:0] a);
    int idx = 0;
    for (int i = 0; i < 6; i++) begin
      logic x = 1'b0;
      for (int k = i; k < 48; k += 6) x ^= a[k];
      idx |= int'(x) << i;
    end
    return idx;
  endfunction

  task automatic testReset();
    chk("R2 valid", int'(resultValid), 0);
    chk("R2 accept", int'(accept), 0);
    chk("R2 reason", int'(dropReason), 0);
    chk("R2 len", int'(frameLen), 0);
  endtask

  task automatic testTiming();
    defaults(); rxLen = LEN_W'(100);
    @(negedge clk) frameEnd = 1'b1;
    @(negedge clk) frameEnd = 1'b0;
    chk("R1 not yet", int'(resultValid), 0);
    @(negedge clk);
    chk("R1 pulse", int'(resultValid), 1);
    chk("R1 len", int'(frameLen), 100);
    rxLen = LEN_W'(200);
    @(negedge clk);
    chk("R1 pulse ends", int'(resultValid), 0);
    chk("R1 held len", int'(frameLen), 100);
    chk("R1 held accept", int'(accept), 1);
  endtask

  task automatic testFcs();
    defaults(); fcsBad = 1'b1;
    expectResult("R3 bad fcs", 1);
    chk("R3 flag", int'(fcsFlag), 1);
    ignoreFcs = 1'b1;
    expectResult("R3 ignored", 0);
    chk("R3 flag kept", int'(fcsFlag), 1);
    defaults();
    expectResult("R3 good", 0);
    chk("R3 flag clear", int'(fcsFlag), 0);
  endtask

  task automatic testSize();
    defaults(); rxLen = LEN_W'(1518); expectResult("R4 std edge", 0);
    rxLen = LEN_W'(1519); expectResult("R4 std over", 2);
    bigEn = 1'b1; rxLen = LEN_W'(1536); expectResult("R4 big edge", 0);
    rxLen = LEN_W'(1537); expectResult("R4 big over", 2);
    jumboEn = 1'b1; rxLen = LEN_W'(10240); expectResult("R4 jumbo edge", 0);
    rxLen = LEN_W'(10241); expectResult("R4 jumbo over", 2);
  endtask

  task automatic testLenField();
    defaults(); lenChkEn = 1'b1; typeLen = 16'd100; rxLen = LEN_W'(80);
    expectResult("R5 short", 3);
    rxLen = LEN_W'(100); expectResult("R5 equal", 0);
    typeLen = 16'h0600; rxLen = LEN_W'(80); expectResult("R5 type value", 0);
    lenChkEn = 1'b0; typeLen = 16'd100; expectResult("R5 disabled", 0);
  endtask

  task automatic testVlan();
    defaults(); vlanOnly = 1'b1; expectResult("R6 untagged", 4);
    vlanTagged = 1'b1; expectResult("R6 tagged", 0);
  endtask

  task automatic testBcast();
    defaults(); specMatch = 1'b0; destAddr = BCAST;
    expectResult("R7 allowed", 0);
    noBcast = 1'b1; expectResult("R7 blocked", 5);
    specMatch = 1'b1; expectResult("R7 blocked spec", 5);
    copyAll = 1'b1; expectResult("R7 copyall", 0);
  endtask

  task automatic testCopyAll();
    defaults(); specMatch = 1'b0; destAddr = 48'h0000_1234_5678;
    expectResult("R8 no match", 5);
    copyAll = 1'b1; expectResult("R8 copy all", 0);
    fcsBad = 1'b1; expectResult("R8 still fcs", 1);
  endtask

  task automatic testHash();
    logic [47:0] uni = 48'h0000_0000_0002;
    logic [47:0] grp = 48'h0100_0000_0003;
    defaults(); specMatch = 1'b0;
    destAddr = uni; hashReg = 64'd1 << hashOf(uni);
    expectResult("R9 uc disabled", 5);
    ucHashEn = 1'b1; expectResult("R9 uc hit", 0);
    hashReg = ~(64'd1 << hashOf(uni)); expectResult("R9 uc miss", 5);
    ucHashEn = 1'b0; mcHashEn = 1'b1; hashReg = 64'd1 << hashOf(uni);
    expectResult("R9 uc via mc en", 5);
    destAddr = grp; hashReg = 64'd1 << hashOf(grp);
    expectResult("R9 mc hit", 0);
    mcHashEn = 1'b0; ucHashEn = 1'b1; expectResult("R9 mc via uc en", 5);
  endtask

  task automatic testPause();
    defaults(); specMatch = 1'b0; pauseValid = 1'b1; copyAll = 1'b1;
    expectResult("R10 allowed", 0);
    noPauseCopy = 1'b1; expectResult("R10 copyall blocked", 5);
    copyAll = 1'b0; typeMatch = 1'b1; expectResult("R10 type blocked", 5);
    specMatch = 1'b1; expectResult("R10 spec passes", 0);
    pauseValid = 1'b0; specMatch = 1'b0; expectResult("R10 non pause", 0);
  endtask

  task automatic testStrip();
    defaults(); stripFcs = 1'b1; rxLen = LEN_W'(64);
    runFrame(); chk("R11 strip", int'(frameLen), 60);
    rxLen = LEN_W'(3); runFrame(); chk("R11 floor", int'(frameLen), 0);
    stripFcs = 1'b0; rxLen = LEN_W'(64);
    runFrame(); chk("R11 keep", int'(frameLen), 64);
  endtask

  task automatic testPriority();
    defaults(); fcsBad = 1'b1; rxLen = LEN_W'(2000); vlanOnly = 1'b1;
    expectResult("R12 fcs first", 1);
    fcsBad = 1'b0; expectResult("R12 size second", 2);
    rxLen = LEN_W'(80); lenChkEn = 1'b1; typeLen = 16'd90; specMatch = 1'b0;
    expectResult("R12 lenf third", 3);
    lenChkEn = 1'b0; expectResult("R12 vlan fourth", 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    testTiming();
    testFcs();
    testSize();
    testLenField();
    testVlan();
    testBcast();
    testCopyAll();
    testHash();
    testPause();
    testStrip();
    testPriority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule